// File: doc/BRIEF.md
# SPI Flash Passthrough Command Filter

This block sits in the path between an upstream SPI host and a downstream serial flash. It watches each transaction as it goes by. It gathers the 8-bit opcode and looks the opcode up in a table of command-description slots. Then it either blocks the command or passes it on. A passed command goes out as a one-cycle opcode beat, followed by a serial stream of bits, one for each host clock. The host side arrives as a one-cycle strobe `host_sck_rise`, driven once per SCK rising edge, with the data bit alongside it. Strobes must be at least three system clocks apart.

For a command that the table marks, the block can change the data on the fly. Chosen address bits can be overwritten from a mask/value pair. Chosen bits of the first 32 host-driven payload bits can be overwritten from a second mask/value pair. The block also tracks whether addresses are 3 or 4 bytes long, and this setting changes when the host sends the enter-4-byte or exit-4-byte opcode. The number of dummy cycles comes from the slot and the lane mode, and the block counts them so that the payload phase starts on the correct bit.

The controller is a state machine with these states:

- `ST_IDLE`: chip select is high.
- `ST_OPCODE`: opcode bits are being shifted in.
- `ST_DECODE`: a single cycle in which the slot lookup and the filter check run.
- `ST_ADDR`, `ST_DUMMY`, `ST_PAYLOAD`: the phases of a command that matched a slot.
- `ST_PASS`: an opcode with no matching slot; all bits pass through unchanged.
- `ST_BLOCK`: a filtered opcode.

The transitions are:

- IDLE→OPCODE on the first strobe while chip select is low.
- OPCODE→DECODE on the eighth bit.
- DECODE→BLOCK, PASS, ADDR, DUMMY or PAYLOAD, in that order of priority.
- ADDR→DUMMY or PAYLOAD on the last address bit.
- DUMMY→PAYLOAD on the last dummy bit.
- Any state→IDLE while `host_csb` is high.

Top module: `spi_pt_filter`

## Requirements
- R1: After reset, `dev_csb` is 1, `addr_4b` is 0, and `dev_op_valid` and `dev_bit_valid` are 0.
- R2: The opcode is taken in MSB first. In the cycle after the strobe that carries the eighth bit, the block decodes the opcode. On the next edge, `dev_op_valid` pulses for one cycle with the opcode on `dev_opcode`, and `dev_csb` goes low if the command is not blocked.
- R3: If `cfg_filter[opcode]` is 1, the block emits no opcode beat and no bits, and `dev_csb` stays 1 until the transaction ends. Once that filter bit is cleared, the same opcode passes again.
- R4: Slot i is held in `cfg_slots[i*18 +: 18]`, laid out as: [17] valid, [16:9] opcode, [8:7] address mode, [6] dummy enable, [5:3] dummy size, [2] host drives payload, [1] address swap enable, [0] payload swap enable. When several slots match, the valid slot with the lowest index wins. Invalid slots are ignored. An opcode that matches no slot has all of its bits forwarded unchanged.
- R5: Address mode 0 means no address. Mode 1 means 24 or 32 bits, following `addr_4b`. Mode 2 always means 24 bits, and mode 3 always means 32 bits. The address is sent MSB first.
- R6: When address swap is enabled, each address bit at position p (counted from the LSB) with `addr_mask[p]`=1 is sent as `addr_value[p]`. Every other address bit is sent as received.
- R7: When payload swap is enabled and the host drives the payload, payload bit k (k=0 first) for k<32 is sent as `pay_value[31-k]` if `pay_mask[31-k]`=1. Later payload bits, and all payload bits of any other command, are sent as received.
- R8: A command with opcode 0xB7 that is not blocked sets `addr_4b`. A command with opcode 0xE9 that is not blocked clears it. The change takes effect from the decode of the next command. A blocked 0xB7 or 0xE9 leaves `addr_4b` unchanged.
- R9: If dummy is disabled, there are 0 dummy cycles. Otherwise the count depends on `lanes`:
  - Single (`lanes`=0): always 7.
  - Dual (`lanes`=1): 3 if size≤3, otherwise 7.
  - Quad (`lanes`=2 or 3): size rounded up to the next odd number.

  Dummy bits are forwarded unchanged.
- R10: When `host_csb` is high, `dev_csb` is 1 on the next edge and the transaction ends. An opcode cut short by chip select produces no output. The next transaction starts a new opcode.
- R11: Each forwarded bit appears on `dev_bit`/`dev_bit_valid` on the clock edge that samples its host strobe. There is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_csb | input | 1 | Upstream chip select, active low |
| host_sck_rise | input | 1 | One-cycle strobe per SCK rising edge |
| host_mosi | input | 1 | Host data bit qualified by the strobe |
| lanes | input | 2 | Lane mode: 0 single, 1 dual, 2/3 quad |
| cfg_filter | input | 256 | One block bit per opcode |
| cfg_slots | input | 432 | 24 packed command-description slots |
| addr_mask | input | 32 | Address bits to overwrite |
| addr_value | input | 32 | Replacement address bits |
| pay_mask | input | 32 | Payload bits to overwrite |
| pay_value | input | 32 | Replacement payload bits |
| dev_csb | output | 1 | Downstream chip select, active low |
| dev_op_valid | output | 1 | One-cycle opcode beat |
| dev_opcode | output | 8 | Forwarded opcode |
| dev_bit_valid | output | 1 | Forwarded bit strobe |
| dev_bit | output | 1 | Forwarded, possibly substituted, bit |
| addr_4b | output | 1 | Current address length, 1 = 4 bytes |

## Verification
The assertions check several rules on every cycle:

- The opcode beat only happens with downstream select low.
- A blocked command stays silent.
- Forwarded bits always trail a host strobe.
- `dev_csb` follows a raised host select.
- `addr_4b` only moves out of a decode.
- Any latched address length is 24 or 32.
- Any latched dummy count is legal for the latched lane mode.

Only the bench scenarios can show the following:

- That substituted bit values land on the right bit positions.
- That the payload starts after exactly the right number of dummy bits.
- That slot priority and invalidation pick the right settings.
- That the 4-byte mode takes effect for the next command and not the current one.

// File: rtl/spi_pt_pkg.sv
package spi_pt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_DECODE,
        ST_ADDR,
        ST_DUMMY,
        ST_PAYLOAD,
        ST_PASS,
        ST_BLOCK
    } pt_state_e;

    // Packed slot layout, MSB first: valid, opcode, address mode,
    // dummy enable, dummy size, host-driven payload, address swap, payload swap.
    typedef struct packed {
        logic       valid;
        logic [7:0] opcode;
        logic [1:0] addr_mode;
        logic       dummy_en;
        logic [2:0] dummy_size;
        logic       pay_in;
        logic       addr_swap;
        logic       pay_swap;
    } slot_cfg_t;

    localparam int SLOT_W = $bits(slot_cfg_t);

    localparam logic [1:0] AM_NONE  = 2'd0;
    localparam logic [1:0] AM_TRACK = 2'd1;
    localparam logic [1:0] AM_3B    = 2'd2;
    localparam logic [1:0] AM_4B    = 2'd3;

    localparam logic [1:0] LANE_SINGLE = 2'd0;
    localparam logic [1:0] LANE_DUAL   = 2'd1;

endpackage

// File: rtl/spi_pt_slot_lookup.sv
module spi_pt_slot_lookup
    import spi_pt_pkg::*;
#(
    parameter int NSLOT = 24
) (
    input  logic [NSLOT*SLOT_W-1:0] slots,
    input  logic [7:0]              opcode,
    output logic                    hit,
    output logic [1:0]              addr_mode,
    output logic                    dummy_en,
    output logic [2:0]              dummy_size,
    output logic                    pay_in,
    output logic                    addr_swap,
    output logic                    pay_swap
);

    slot_cfg_t        ent [NSLOT];
    logic [NSLOT-1:0] match;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign ent[g]   = slot_cfg_t'(slots[g*SLOT_W +: SLOT_W]);
        assign match[g] = ent[g].valid && (ent[g].opcode == opcode);
    end

    // Walk from the highest index down so the lowest matching index wins.
    always_comb begin
        hit        = 1'b0;
        addr_mode  = AM_NONE;
        dummy_en   = 1'b0;
        dummy_size = 3'd0;
        pay_in     = 1'b0;
        addr_swap  = 1'b0;
        pay_swap   = 1'b0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit        = 1'b1;
                addr_mode  = ent[i].addr_mode;
                dummy_en   = ent[i].dummy_en;
                dummy_size = ent[i].dummy_size;
                pay_in     = ent[i].pay_in;
                addr_swap  = ent[i].addr_swap;
                pay_swap   = ent[i].pay_swap;
            end
        end
    end

endmodule

// File: rtl/spi_pt_dummy_calc.sv
module spi_pt_dummy_calc
    import spi_pt_pkg::*;
(
    input  logic [1:0] lanes,
    input  logic       enable,
    input  logic [2:0] size,
    output logic [2:0] cycles
);

    always_comb begin
        if (!enable) begin
            cycles = 3'd0;
        end else begin
            unique case (lanes)
                LANE_SINGLE: cycles = 3'd7;
                LANE_DUAL:   cycles = (size <= 3'd3) ? 3'd3 : 3'd7;
                default:     cycles = {size[2:1], 1'b1};
            endcase
        end
    end

endmodule

// File: rtl/spi_pt_bit_subst.sv
module spi_pt_bit_subst #(
    parameter int W     = 32,
    localparam int IDX_W = $clog2(W)
) (
    input  logic             enable,
    input  logic [W-1:0]     mask,
    input  logic [W-1:0]     value,
    input  logic [IDX_W-1:0] idx,
    input  logic             din,
    output logic             dout
);

    always_comb begin
        dout = din;
        if (enable && mask[idx]) begin
            dout = value[idx];
        end
    end

endmodule

// File: rtl/spi_pt_addr_mode.sv
module spi_pt_addr_mode #(
    parameter bit RESET_4B = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic go_4b,
    input  logic go_3b,
    output logic addr_4b
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_4b <= RESET_4B;
        end else if (upd_en && go_4b) begin
            addr_4b <= 1'b1;
        end else if (upd_en && go_3b) begin
            addr_4b <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_pt_filter.sv
module spi_pt_filter
    import spi_pt_pkg::*;
#(
    parameter int         NSLOT     = 24,
    parameter int         ADDR_W    = 32,
    parameter int         PAY_BITS  = 32,
    parameter logic [7:0] OP_ENTER4 = 8'hB7,
    parameter logic [7:0] OP_EXIT4  = 8'hE9,
    parameter bit         RESET_4B  = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_csb,
    input  logic                    host_sck_rise,
    input  logic                    host_mosi,
    input  logic [1:0]              lanes,
    input  logic [255:0]            cfg_filter,
    input  logic [NSLOT*SLOT_W-1:0] cfg_slots,
    input  logic [ADDR_W-1:0]       addr_mask,
    input  logic [ADDR_W-1:0]       addr_value,
    input  logic [PAY_BITS-1:0]     pay_mask,
    input  logic [PAY_BITS-1:0]     pay_value,
    output logic                    dev_csb,
    output logic                    dev_op_valid,
    output logic [7:0]              dev_opcode,
    output logic                    dev_bit_valid,
    output logic                    dev_bit,
    output logic                    addr_4b
);

    localparam int MAXC   = (ADDR_W > PAY_BITS) ? ADDR_W : PAY_BITS;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam int AIDX_W = $clog2(ADDR_W);
    localparam int PIDX_W = $clog2(PAY_BITS);
    localparam int ALEN3  = ADDR_W - 8;
    localparam int ALEN4  = ADDR_W;

    pt_state_e state_q, state_d;

    logic [7:0]       op_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] alen_q;
    logic [2:0]       dum_q;
    logic [1:0]       lanes_q;
    logic             aswap_q;
    logic             pswap_q;

    // ---------------- decode-cycle lookup ----------------
    logic       look_hit, look_den, look_pin, look_aswap, look_pswap;
    logic [1:0] look_am;
    logic [2:0] look_dsz;
    logic [2:0] dec_dum;
    logic [CNT_W-1:0] dec_alen;
    logic       dec_block;
    pt_state_e  dec_next;

    spi_pt_slot_lookup #(.NSLOT(NSLOT)) u_lookup (
        .slots      (cfg_slots),
        .opcode     (op_q),
        .hit        (look_hit),
        .addr_mode  (look_am),
        .dummy_en   (look_den),
        .dummy_size (look_dsz),
        .pay_in     (look_pin),
        .addr_swap  (look_aswap),
        .pay_swap   (look_pswap)
    );

    spi_pt_dummy_calc u_dummy (
        .lanes  (lanes),
        .enable (look_den),
        .size   (look_dsz),
        .cycles (dec_dum)
    );

    assign dec_block = cfg_filter[op_q];

    always_comb begin
        unique case (look_am)
            AM_NONE:  dec_alen = '0;
            AM_TRACK: dec_alen = addr_4b ? CNT_W'(ALEN4) : CNT_W'(ALEN3);
            AM_3B:    dec_alen = CNT_W'(ALEN3);
            default:  dec_alen = CNT_W'(ALEN4);
        endcase
    end

    always_comb begin
        if (dec_block)               dec_next = ST_BLOCK;
        else if (!look_hit)          dec_next = ST_PASS;
        else if (dec_alen != '0)     dec_next = ST_ADDR;
        else if (dec_dum != 3'd0)    dec_next = ST_DUMMY;
        else                         dec_next = ST_PAYLOAD;
    end

    // ---------------- address-length tracking ----------------
    logic mode_upd;
    assign mode_upd = (state_q == ST_DECODE) && !host_csb && !dec_block;

    spi_pt_addr_mode #(.RESET_4B(RESET_4B)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (mode_upd),
        .go_4b   (op_q == OP_ENTER4),
        .go_3b   (op_q == OP_EXIT4),
        .addr_4b (addr_4b)
    );

    // ---------------- phase boundaries ----------------
    logic addr_last, dum_last, op_last;
    assign op_last   = (cnt_q == CNT_W'(7));
    assign addr_last = (cnt_q == alen_q - CNT_W'(1));
    assign dum_last  = (cnt_q == CNT_W'(dum_q) - CNT_W'(1));

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (host_csb) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_OPCODE: begin
                    if (host_sck_rise) state_d = op_last ? ST_DECODE : ST_OPCODE;
                end
                ST_DECODE: state_d = dec_next;
                ST_ADDR: begin
                    if (host_sck_rise && addr_last)
                        state_d = (dum_q != 3'd0) ? ST_DUMMY : ST_PAYLOAD;
                end
                ST_DUMMY: begin
                    if (host_sck_rise && dum_last) state_d = ST_PAYLOAD;
                end
                ST_PAYLOAD, ST_PASS, ST_BLOCK: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- counters and per-command settings ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            cnt_q   <= '0;
            alen_q  <= '0;
            dum_q   <= '0;
            lanes_q <= '0;
            aswap_q <= 1'b0;
            pswap_q <= 1'b0;
        end else if (host_csb) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_OPCODE: begin
                    if (host_sck_rise) begin
                        op_q  <= {op_q[6:0], host_mosi};
                        cnt_q <= op_last ? '0 : cnt_q + CNT_W'(1);
                    end
                end
                ST_DECODE: begin
                    alen_q  <= dec_alen;
                    dum_q   <= dec_dum;
                    lanes_q <= lanes;
                    aswap_q <= look_aswap;
                    pswap_q <= look_pswap && look_pin;
                    cnt_q   <= '0;
                end
                ST_ADDR: begin
                    if (host_sck_rise) cnt_q <= addr_last ? '0 : cnt_q + CNT_W'(1);
                end
                ST_DUMMY: begin
                    if (host_sck_rise) cnt_q <= dum_last ? '0 : cnt_q + CNT_W'(1);
                end
                ST_PAYLOAD: begin
                    if (host_sck_rise && (cnt_q < CNT_W'(PAY_BITS))) cnt_q <= cnt_q + CNT_W'(1);
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // ---------------- bit substitution ----------------
    logic [AIDX_W-1:0] addr_idx;
    logic [PIDX_W-1:0] pay_idx;
    logic              addr_bit, pay_bit, pay_window;

    assign addr_idx   = AIDX_W'(alen_q - cnt_q - CNT_W'(1));
    assign pay_idx    = PIDX_W'(CNT_W'(PAY_BITS - 1) - cnt_q);
    assign pay_window = cnt_q < CNT_W'(PAY_BITS);

    spi_pt_bit_subst #(.W(ADDR_W)) u_addr_sub (
        .enable (aswap_q),
        .mask   (addr_mask),
        .value  (addr_value),
        .idx    (addr_idx),
        .din    (host_mosi),
        .dout   (addr_bit)
    );

    spi_pt_bit_subst #(.W(PAY_BITS)) u_pay_sub (
        .enable (pswap_q && pay_window),
        .mask   (pay_mask),
        .value  (pay_value),
        .idx    (pay_idx),
        .din    (host_mosi),
        .dout   (pay_bit)
    );

    // ---------------- outputs ----------------
    logic fwd, next_bit;
    assign fwd = !host_csb && host_sck_rise &&
                 ((state_q == ST_ADDR) || (state_q == ST_DUMMY) ||
                  (state_q == ST_PAYLOAD) || (state_q == ST_PASS));

    always_comb begin
        unique case (state_q)
            ST_ADDR:    next_bit = addr_bit;
            ST_PAYLOAD: next_bit = pay_bit;
            default:    next_bit = host_mosi;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_csb       <= 1'b1;
            dev_op_valid  <= 1'b0;
            dev_opcode    <= '0;
            dev_bit_valid <= 1'b0;
            dev_bit       <= 1'b0;
        end else begin
            dev_op_valid  <= 1'b0;
            dev_bit_valid <= fwd;
            if (fwd) dev_bit <= next_bit;
            if (host_csb) begin
                dev_csb <= 1'b1;
            end else if (state_q == ST_DECODE) begin
                dev_csb      <= dec_block;
                dev_op_valid <= !dec_block;
                dev_opcode   <= op_q;
            end
        end
    end

    // ---------------- assertions ----------------
    p_op_beat_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dev_op_valid |-> !dev_csb);

    p_blocked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCK) |-> (dev_csb && !dev_op_valid && !dev_bit_valid));

    p_addr_len_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |-> ((alen_q == CNT_W'(ALEN3)) || (alen_q == CNT_W'(ALEN4))));

    p_mode_moves_at_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_4b != $past(addr_4b)) |-> $past(state_q == ST_DECODE));

    p_dummy_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DUMMY) |->
            ((lanes_q == LANE_SINGLE) ? (dum_q == 3'd7) :
             (lanes_q == LANE_DUAL)   ? ((dum_q == 3'd3) || (dum_q == 3'd7)) :
                                        dum_q[0]));

    p_csb_follows_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_csb) |-> dev_csb);

    p_bit_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dev_bit_valid |-> $past(host_sck_rise));

endmodule

// File: tb/spi_pt_filter_tb.sv
module spi_pt_filter_tb_top;

    localparam int NS = 24;
    localparam int SW = 18;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              host_csb, host_sck_rise, host_mosi;
    logic [1:0]        lanes;
    logic [255:0]      cfg_filter;
    logic [NS*SW-1:0]  cfg_slots;
    logic [31:0]       addr_mask, addr_value, pay_mask, pay_value;
    logic              dev_csb, dev_op_valid, dev_bit_valid, dev_bit, addr_4b;
    logic [7:0]        dev_opcode;

    always #10 clk = ~clk;  // 50 MHz

    spi_pt_filter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_csb      (host_csb),
        .host_sck_rise (host_sck_rise),
        .host_mosi     (host_mosi),
        .lanes         (lanes),
        .cfg_filter    (cfg_filter),
        .cfg_slots     (cfg_slots),
        .addr_mask     (addr_mask),
        .addr_value    (addr_value),
        .pay_mask      (pay_mask),
        .pay_value     (pay_value),
        .dev_csb       (dev_csb),
        .dev_op_valid  (dev_op_valid),
        .dev_opcode    (dev_opcode),
        .dev_bit_valid (dev_bit_valid),
        .dev_bit       (dev_bit),
        .addr_4b       (addr_4b)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int strobe_cyc = 0;
    bit done = 0;
    bit mode4b_m = 0;

    logic [17:0] slot_m [NS];
    logic [8:0]  exp_q [$];
    string       tag_q [$];
    bit          stim_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    // ---------------- monitor: pops the scoreboard ----------------
    task automatic sb_pop(input logic [8:0] got);
        if (exp_q.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R3/R10 unexpected output: actual %0h expected none", got);
        end else begin
            logic [8:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {23'd0, got}, {23'd0, e});
        end
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (dev_op_valid) sb_pop({1'b1, dev_opcode});
            if (dev_bit_valid) begin
                sb_pop({8'd0, dev_bit});
                chk("R11 latency", cyc, strobe_cyc + 1);
            end
        end
    end

    // ---------------- driver helpers ----------------
    function automatic logic [17:0] mkslot(input bit v, input logic [7:0] op, input logic [1:0] am,
                                           input bit den, input logic [2:0] dsz, input bit pin,
                                           input bit asw, input bit psw);
        return {v, op, am, den, dsz, pin, asw, psw};
    endfunction

    task automatic apply_cfg();
        for (int i = 0; i < NS; i++) cfg_slots[i*SW +: SW] = slot_m[i];
    endtask

    task automatic add_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) stim_q.push_back(v[i]);
    endtask

    task automatic send_bit(input logic b);
        host_mosi     = b;
        host_sck_rise = 1'b1;
        strobe_cyc    = cyc;
        @(negedge clk);
        host_sck_rise = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int dummy_model(input logic [1:0] ln, input logic [2:0] sz);
        if (ln == 2'd0) return 7;
        if (ln == 2'd1) return (sz <= 3) ? 3 : 7;
        return (sz % 2 == 1) ? int'(sz) : int'(sz) + 1;
    endfunction

    // Builds the expected stream from the requirements, then drives the transaction.
    task automatic run_txn(input logic [7:0] op, input logic [1:0] ln);
        int          hit_i = -1;
        int          alen = 0;
        int          d = 0;
        bit          blk;
        logic [17:0] s = '0;
        for (int i = 0; i < NS; i++)
            if (hit_i < 0 && slot_m[i][17] && slot_m[i][16:9] == op) hit_i = i;
        blk = cfg_filter[op];
        if (hit_i >= 0) begin
            s = slot_m[hit_i];
            case (s[8:7])
                2'd0: alen = 0;
                2'd1: alen = mode4b_m ? 32 : 24;
                2'd2: alen = 24;
                default: alen = 32;
            endcase
            d = s[6] ? dummy_model(ln, s[5:3]) : 0;
        end
        if (!blk) begin
            exp_q.push_back({1'b1, op}); tag_q.push_back("R2 opcode");
            for (int j = 0; j < stim_q.size(); j++) begin
                logic  b;
                string t;
                b = stim_q[j];
                if (hit_i < 0) t = "R4 pass";
                else if (j < alen) begin
                    t = "R6 addr";
                    if (s[1] && addr_mask[alen-1-j]) b = addr_value[alen-1-j];
                end else if (j < alen + d) t = "R9 dummy";
                else begin
                    int k;
                    k = j - alen - d;
                    t = "R7 payload";
                    if (s[0] && s[2] && k < 32 && pay_mask[31-k]) b = pay_value[31-k];
                end
                exp_q.push_back({8'd0, b}); tag_q.push_back(t);
            end
        end
        lanes = ln;
        @(negedge clk);
        host_csb = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 7; i >= 0; i--) send_bit(op[i]);
        chk(blk ? "R3 csb held high" : "R2 csb low", {31'd0, dev_csb}, {31'd0, blk});
        for (int j = 0; j < stim_q.size(); j++) send_bit(stim_q[j]);
        repeat (2) @(negedge clk);
        host_csb = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 csb high at end", {31'd0, dev_csb}, 32'd1);
        chk("R2/R3 all items seen", exp_q.size(), 0);
        if (!blk && op == 8'hB7) mode4b_m = 1;
        if (!blk && op == 8'hE9) mode4b_m = 0;
        stim_q.delete();
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0; host_csb = 1'b1; host_sck_rise = 1'b0; host_mosi = 1'b0;
        lanes = 2'd0; cfg_filter = '0; cfg_slots = '0;
        addr_mask = 32'h0F00F000; addr_value = 32'h0A00A000;
        pay_mask  = 32'hF000000F; pay_value  = 32'hA0000005;
        for (int i = 0; i < NS; i++) slot_m[i] = '0;
        slot_m[0]  = mkslot(1, 8'hB7, 2'd0, 0, 3'd0, 0, 0, 0);
        slot_m[1]  = mkslot(1, 8'hE9, 2'd0, 0, 3'd0, 0, 0, 0);
        slot_m[2]  = mkslot(1, 8'h05, 2'd0, 0, 3'd0, 0, 0, 0);
        slot_m[5]  = mkslot(1, 8'h03, 2'd1, 0, 3'd0, 0, 0, 0);
        slot_m[6]  = mkslot(1, 8'h0B, 2'd1, 1, 3'd7, 0, 0, 0);
        slot_m[7]  = mkslot(1, 8'h3B, 2'd2, 1, 3'd2, 1, 0, 1);
        slot_m[8]  = mkslot(1, 8'h6B, 2'd3, 1, 3'd4, 1, 0, 1);
        slot_m[11] = mkslot(1, 8'h02, 2'd1, 0, 3'd0, 1, 1, 1);
        slot_m[12] = mkslot(1, 8'h0B, 2'd1, 0, 3'd0, 0, 1, 0);
        slot_m[13] = mkslot(1, 8'h01, 2'd0, 0, 3'd0, 1, 0, 1);
        apply_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 dev_csb", {31'd0, dev_csb}, 32'd1);
        chk("R1 addr_4b", {31'd0, addr_4b}, 32'd0);
        chk("R1 op_valid", {31'd0, dev_op_valid}, 32'd0);
        chk("R1 bit_valid", {31'd0, dev_bit_valid}, 32'd0);

        // R2 R5: plain read, tracked 3-byte address, no swap
        add_bits(32'h123456, 24); add_bits(32'h5A, 8);
        run_txn(8'h03, 2'd0);

        // R6 R7: program with address and payload swap, 40 payload bits
        add_bits(32'hABCDEF, 24); add_bits(32'h0, 32); add_bits(32'hFF, 8);
        run_txn(8'h02, 2'd0);

        // R7: host-driven payload swap without address; payload not swapped when direction is out
        add_bits(32'h3C3C, 16);
        run_txn(8'h01, 2'd0);
        add_bits(32'hFFFF, 16);
        run_txn(8'h05, 2'd0);

        // R3: filtered then unfiltered
        cfg_filter[8'h03] = 1'b1;
        add_bits(32'h111111, 24);
        run_txn(8'h03, 2'd0);
        cfg_filter[8'h03] = 1'b0;
        add_bits(32'h222222, 24);
        run_txn(8'h03, 2'd0);

        // R4: priority by lowest index, then invalidation of the winner
        add_bits(32'h00F0F0, 24); add_bits(32'h0, 7); add_bits(32'h5, 4);
        run_txn(8'h0B, 2'd2);
        slot_m[6][17] = 1'b0; apply_cfg();
        add_bits(32'h00F0F0, 24); add_bits(32'h9, 4);
        run_txn(8'h0B, 2'd0);
        slot_m[6][17] = 1'b1; apply_cfg();

        // R4: no matching slot passes everything unchanged
        add_bits(32'hC3A5F0, 24);
        run_txn(8'h9F, 2'd0);

        // R8: blocked enter-4B leaves mode alone
        cfg_filter[8'hB7] = 1'b1;
        run_txn(8'hB7, 2'd0);
        chk("R8 blocked enter", {31'd0, addr_4b}, 32'd0);
        cfg_filter[8'hB7] = 1'b0;
        run_txn(8'hB7, 2'd0);
        chk("R8 enter 4B", {31'd0, addr_4b}, 32'd1);

        // R5 R6 with 32-bit addresses
        add_bits(32'h87654321, 32); add_bits(32'h0, 8);
        run_txn(8'h03, 2'd0);
        add_bits(32'hF1E2D3C4, 32); add_bits(32'hFFFFFFFF, 32);
        run_txn(8'h02, 2'd0);
        run_txn(8'hE9, 2'd0);
        chk("R8 exit 4B", {31'd0, addr_4b}, 32'd0);

        // R9: dummy counts per lane mode; swapped payload marks where dummies end
        for (int ln = 0; ln < 3; ln++) begin
            add_bits(32'h0, 24); add_bits(32'h0, 12);
            run_txn(8'h3B, 2'(ln));
        end
        for (int ln = 1; ln < 3; ln++) begin
            add_bits(32'h0, 32); add_bits(32'h0, 12);
            run_txn(8'h6B, 2'(ln));
        end

        // R10: opcode cut short produces nothing, then a clean command
        @(negedge clk);
        host_csb = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        host_csb = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 partial csb", {31'd0, dev_csb}, 32'd1);
        chk("R10 partial silent", exp_q.size(), 0);
        add_bits(32'h0000AA, 24);
        run_txn(8'h03, 2'd0);

        finish_run();
    end

endmodule